// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Two-Entry Status Queue

This block receives asynchronous serial frames on a single line and hands them to a register-style read port. The line is oversampled by a clock-enable tick running at sixteen times the bit rate, which a baud-rate generator outside the block supplies. Each frame has one low start bit, eight data bits sent least significant bit first, an optional ninth data bit, and one stop bit. A shift register builds the frame. When the stop bit is decided, the frame moves into a two-entry queue.

Each queue entry holds the data byte, the ninth bit and a framing-error flag. The read port always shows the oldest entry. A one-cycle pop strobe discards that entry, so software must read the status before it pops. A data-available flag is high while the queue holds anything, and an interrupt output gates that flag with an enable input.

If a frame completes while both entries are occupied, the block raises a sticky overrun flag and drops the frame. From then on no frame enters the queue until the receive enable is taken low and then high again. Taking the enable low also returns the receive logic to idle. Entries already in the queue are kept.

Top module: `async_rx_queue`

## Requirements
- R1: After reset `data_avail`, `irq` and `overrun` are low.
- R2: In 8-bit mode (`nine_bit_mode`=0) a frame is a low start bit, eight data bits with bit 0 first, and a stop bit. The byte appears on `rd_data` and `rd_bit9` reads 0.
- R3: In 9-bit mode (`nine_bit_mode`=1) the ninth data bit follows data bit 7 on the line and appears on `rd_bit9`.
- R4: A low level on the idle line that has ended before the middle of the start bit, eight ticks after the falling edge, is ignored and produces no frame.
- R5: Each bit value is the majority of the samples taken at ticks 7, 8 and 9 of the sixteen ticks in that bit. A disturbance that covers a single tick does not change the bit.
- R6: `rd_ferr` is 1 for an entry whose stop bit was decided low and 0 otherwise. `rd_data`, `rd_bit9` and `rd_ferr` all describe the head entry, and they change together when it is popped.
- R7: The queue holds two entries and returns them in arrival order. `data_avail` is high exactly while the queue is not empty. A pop while the queue is empty has no effect.
- R8: `irq` is high when `data_avail` and `irq_en` are both high, and low otherwise.
- R9: A frame that completes while the queue is full sets `overrun` and is discarded.
- R10: While `overrun` is high and `rx_en` stays high, `overrun` stays set and no frame enters the queue, even after entries have been popped.
- R11: While `rx_en` is low no frame is received and `overrun` is cleared. After `rx_en` returns high, reception resumes and the queue contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | Sample enable at sixteen times the bit rate |
| rx_line | input | 1 | Serial input line, idle high |
| rx_en | input | 1 | Receive enable; low holds the receiver idle and clears overrun |
| nine_bit_mode | input | 1 | 1 selects frames with nine data bits |
| irq_en | input | 1 | Interrupt enable |
| rd_pop | input | 1 | One-cycle strobe that removes the head entry |
| rd_data | output | 8 | Data byte of the head entry |
| rd_bit9 | output | 1 | Ninth data bit of the head entry |
| rd_ferr | output | 1 | Framing-error flag of the head entry |
| data_avail | output | 1 | Queue not empty |
| irq | output | 1 | Data-available interrupt |
| overrun | output | 1 | Sticky overrun flag |

## Verification
The hardest state to reach is a frame completing while the overrun flag is already set and the queue has a free slot. That frame must still be dropped.

The bench gets there by turning the scoreboard's popping monitor off and sending three frames back to back. This fills the queue and raises overrun. It then pops a single entry and sends a fourth frame. Draining the queue must then yield only the first two frames.

A later step toggles the enable and confirms that reception resumes.

// File: rtl/rxq_pkg.sv
`timescale 1ns/1ps
package rxq_pkg;
    localparam int DATA_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_DATA  = 2'd2,
        ST_STOP  = 2'd3
    } rx_state_e;

    typedef struct packed {
        logic              ferr;
        logic              bit9;
        logic [DATA_W-1:0] data;
    } rxq_entry_t;
endpackage

// File: rtl/rxq_sync.sv
`timescale 1ns/1ps
module rxq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sync_d, sync_q;

    always_comb begin
        sync_d = {sync_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= sync_d;
    end

    assign dout = sync_q[STAGES-1];
endmodule

// File: rtl/rxq_bitrx.sv
`timescale 1ns/1ps
module rxq_bitrx
    import rxq_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       rx_s,
    input  logic       en,
    input  logic       mode9,
    output logic       frame_vld,
    output rxq_entry_t frame
);
    localparam int CW  = $clog2(OVS);
    localparam int SA  = OVS / 2 - 1;
    localparam int SB  = OVS / 2;
    localparam int SC  = OVS / 2 + 1;
    localparam int IW  = $clog2(DATA_W + 2);

    typedef struct packed {
        rx_state_e     st;
        logic [CW-1:0] cnt;
        logic [IW-1:0] idx;
        logic [1:0]    ones;
        logic [DATA_W:0] sh;
        logic          vld;
        rxq_entry_t    ent;
    } bitrx_t;

    bitrx_t r_d, r_q;
    logic [1:0]    vote_ones;
    logic          bit_val;
    logic [IW-1:0] last_idx;
    logic          at_end;

    always_comb begin
        r_d       = r_q;
        r_d.vld   = 1'b0;
        vote_ones = r_q.ones + 2'(rx_s);
        bit_val   = (vote_ones >= 2'd2);
        last_idx  = mode9 ? IW'(DATA_W) : IW'(DATA_W - 1);
        at_end    = (r_q.cnt == CW'(OVS - 1));

        if (!en) begin
            r_d    = '0;
            r_d.st = ST_IDLE;
        end else if (tick) begin
            if (r_q.st == ST_IDLE) begin
                if (!rx_s) begin
                    r_d.st   = ST_START;
                    r_d.cnt  = CW'(1);
                    r_d.ones = 2'd0;
                end
            end else begin
                r_d.cnt = at_end ? '0 : r_q.cnt + CW'(1);
                if (r_q.cnt == CW'(SA) || r_q.cnt == CW'(SB)) begin
                    r_d.ones = vote_ones;
                end
                case (r_q.st)
                    ST_START: begin
                        if (r_q.cnt == CW'(SB) && rx_s) begin
                            r_d.st  = ST_IDLE;
                            r_d.cnt = '0;
                        end else if (at_end) begin
                            r_d.st   = ST_DATA;
                            r_d.idx  = '0;
                            r_d.ones = 2'd0;
                            r_d.sh   = '0;
                        end
                    end
                    ST_DATA: begin
                        if (r_q.cnt == CW'(SC)) begin
                            for (int b = 0; b <= DATA_W; b++) begin
                                if (r_q.idx == IW'(b)) r_d.sh[b] = bit_val;
                            end
                            r_d.ones = 2'd0;
                        end
                        if (at_end) begin
                            if (r_q.idx == last_idx) r_d.st = ST_STOP;
                            else                     r_d.idx = r_q.idx + IW'(1);
                        end
                    end
                    ST_STOP: begin
                        if (r_q.cnt == CW'(SC)) begin
                            r_d.vld      = 1'b1;
                            r_d.ent.data = r_q.sh[DATA_W-1:0];
                            r_d.ent.bit9 = mode9 & r_q.sh[DATA_W];
                            r_d.ent.ferr = ~bit_val;
                            r_d.st       = ST_IDLE;
                            r_d.cnt      = '0;
                            r_d.ones     = 2'd0;
                        end
                    end
                    default: r_d.st = ST_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign frame_vld = r_q.vld;
    assign frame     = r_q.ent;
endmodule

// File: rtl/rxq_fifo.sv
`timescale 1ns/1ps
module rxq_fifo
    import rxq_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic                       pop,
    input  rxq_entry_t                 wdata,
    output rxq_entry_t                 head,
    output logic                       empty,
    output logic                       full,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int PW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int NW  = $clog2(DEPTH + 1);

    typedef struct packed {
        rxq_entry_t [DEPTH-1:0] mem;
        logic [PW-1:0]          wp;
        logic [PW-1:0]          rp;
        logic [NW-1:0]          cnt;
    } fifo_t;

    fifo_t f_d, f_q;
    logic  do_push, do_pop;

    always_comb begin
        f_d     = f_q;
        do_pop  = pop && (f_q.cnt != '0);
        do_push = push && (f_q.cnt != NW'(DEPTH));
        if (do_push) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (f_q.wp == PW'(i)) f_d.mem[i] = wdata;
            end
            f_d.wp = (f_q.wp == PW'(DEPTH - 1)) ? '0 : f_q.wp + PW'(1);
        end
        if (do_pop) begin
            f_d.rp = (f_q.rp == PW'(DEPTH - 1)) ? '0 : f_q.rp + PW'(1);
        end
        case ({do_push, do_pop})
            2'b10:   f_d.cnt = f_q.cnt + NW'(1);
            2'b01:   f_d.cnt = f_q.cnt - NW'(1);
            default: f_d.cnt = f_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    always_comb begin
        head = f_q.mem[0];
        for (int i = 0; i < DEPTH; i++) begin
            if (f_q.rp == PW'(i)) head = f_q.mem[i];
        end
    end

    assign empty = (f_q.cnt == '0);
    assign full  = (f_q.cnt == NW'(DEPTH));
    assign count = f_q.cnt;
endmodule

// File: rtl/async_rx_queue.sv
`timescale 1ns/1ps
module async_rx_queue
    import rxq_pkg::*;
#(
    parameter int OVS   = 16,
    parameter int DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick16,
    input  logic              rx_line,
    input  logic              rx_en,
    input  logic              nine_bit_mode,
    input  logic              irq_en,
    input  logic              rd_pop,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_bit9,
    output logic              rd_ferr,
    output logic              data_avail,
    output logic              irq,
    output logic              overrun
);
    localparam int NW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic ovr;
    } top_t;

    logic          rx_s;
    logic          frame_vld;
    rxq_entry_t    frame;
    rxq_entry_t    head;
    logic          fifo_empty, fifo_full;
    logic [NW-1:0] fifo_cnt;
    logic          push;
    top_t          t_d, t_q;

    rxq_sync #(.STAGES(2)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rx_line),
        .dout (rx_s)
    );

    rxq_bitrx #(.OVS(OVS)) u_bitrx (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick16),
        .rx_s     (rx_s),
        .en       (rx_en),
        .mode9    (nine_bit_mode),
        .frame_vld(frame_vld),
        .frame    (frame)
    );

    always_comb begin
        t_d  = t_q;
        push = frame_vld && !t_q.ovr && !fifo_full;
        if (!rx_en)                                 t_d.ovr = 1'b0;
        else if (frame_vld && !t_q.ovr && fifo_full) t_d.ovr = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    rxq_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk  (clk),
        .rst_n(rst_n),
        .push (push),
        .pop  (rd_pop),
        .wdata(frame),
        .head (head),
        .empty(fifo_empty),
        .full (fifo_full),
        .count(fifo_cnt)
    );

    assign rd_data    = head.data;
    assign rd_bit9    = head.bit9;
    assign rd_ferr    = head.ferr;
    assign data_avail = !fifo_empty;
    assign irq        = data_avail & irq_en;
    assign overrun    = t_q.ovr;
endmodule

// File: rtl/rxq_checker.sv
`timescale 1ns/1ps
module rxq_checker #(
    parameter int DEPTH = 2,
    parameter int NW    = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rx_en,
    input logic          rd_pop,
    input logic          data_avail,
    input logic          overrun,
    input logic          frame_vld,
    input logic          push,
    input logic          full,
    input logic [NW-1:0] count
);
    a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= NW'(DEPTH));

    a_r7_empty_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (count == NW'(1) && rd_pop && !push) |=> !data_avail);

    a_r9_overrun_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> $past(frame_vld && full));

    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && rx_en) |=> overrun);

    a_r10_no_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !data_avail) |=> !data_avail);

    a_r11_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !overrun);

    a_r11_no_frame: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !frame_vld);
endmodule

bind async_rx_queue rxq_checker #(.DEPTH(DEPTH)) u_rxq_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_en     (rx_en),
    .rd_pop    (rd_pop),
    .data_avail(data_avail),
    .overrun   (overrun),
    .frame_vld (frame_vld),
    .push      (push),
    .full      (fifo_full),
    .count     (fifo_cnt)
);

// File: tb/async_rx_queue_bench.sv
`timescale 1ns/1ps
module async_rx_queue_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16;
    logic       rx_line = 1'b1;
    logic       rx_en = 1'b0;
    logic       nine_bit_mode = 1'b0;
    logic       irq_en = 1'b0;
    logic       rd_pop = 1'b0;
    logic [7:0] rd_data;
    logic       rd_bit9, rd_ferr, data_avail, irq, overrun;

    int total = 0;
    int bad   = 0;
    bit mon_on = 1'b0;
    logic [1:0] tdiv = 2'd0;
    logic [9:0] expq[$];

    localparam int BITCLK = 64;

    always #10 clk = ~clk;

    always_ff @(posedge clk) tdiv <= tdiv + 2'd1;
    assign tick16 = (tdiv == 2'd3);

    async_rx_queue u_async_rx_queue (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick16       (tick16),
        .rx_line      (rx_line),
        .rx_en        (rx_en),
        .nine_bit_mode(nine_bit_mode),
        .irq_en       (irq_en),
        .rd_pop       (rd_pop),
        .rd_data      (rd_data),
        .rd_bit9      (rd_bit9),
        .rd_ferr      (rd_ferr),
        .data_avail   (data_avail),
        .irq          (irq),
        .overrun      (overrun)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drive_frame(input logic [8:0] val, input bit nine, input logic stop_lvl, input bit glitch);
        int nb;
        nb = nine ? 9 : 8;
        @(negedge clk);
        rx_line = 1'b0;
        idle(BITCLK);
        for (int i = 0; i < nb; i++) begin
            rx_line = val[i];
            if (glitch) begin
                idle(30);
                rx_line = ~val[i];
                idle(4);
                rx_line = val[i];
                idle(30);
            end else begin
                idle(BITCLK);
            end
        end
        rx_line = stop_lvl;
        idle(BITCLK);
        rx_line = 1'b1;
        idle(BITCLK);
    endtask

    task automatic send_exp(input logic [8:0] val, input bit nine, input logic stop_lvl, input bit glitch);
        expq.push_back({~stop_lvl, nine ? val[8] : 1'b0, val[7:0]});
        drive_frame(val, nine, stop_lvl, glitch);
    endtask

    task automatic pop_once();
        @(negedge clk);
        rd_pop = 1'b1;
        @(negedge clk);
        rd_pop = 1'b0;
        @(negedge clk);
    endtask

    // scoreboard monitor: R2 R3 R5 R6 R7
    initial begin
        forever begin
            @(negedge clk);
            if (mon_on) begin
                if (rd_pop) begin
                    rd_pop = 1'b0;
                end else if (data_avail) begin
                    if (expq.size() == 0) begin
                        check(1'b0, "R7 unexpected entry", {22'd0, rd_ferr, rd_bit9, rd_data}, 32'd0);
                    end else begin
                        logic [9:0] e;
                        e = expq.pop_front();
                        check({rd_ferr, rd_bit9, rd_data} == e, "R2 R3 R6 entry",
                              {22'd0, rd_ferr, rd_bit9, rd_data}, {22'd0, e});
                    end
                    rd_pop = 1'b1;
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle(5);
        // R1 reset state
        check(data_avail == 1'b0, "R1 data_avail", data_avail, 0);
        check(irq == 1'b0, "R1 irq", irq, 0);
        check(overrun == 1'b0, "R1 overrun", overrun, 0);
        rst_n = 1'b1;
        idle(5);
        check(data_avail == 1'b0 && overrun == 1'b0, "R1 after release", {data_avail, overrun}, 0);

        rx_en = 1'b1;
        irq_en = 1'b1;
        mon_on = 1'b1;
        idle(BITCLK);

        // R2 eight-bit frames, bit 0 first
        send_exp(9'h0A5, 1'b0, 1'b1, 1'b0);
        send_exp(9'h001, 1'b0, 1'b1, 1'b0);
        send_exp(9'h080, 1'b0, 1'b1, 1'b0);
        send_exp(9'h03C, 1'b0, 1'b1, 1'b0);
        // R6 stop bit low
        send_exp(9'h05A, 1'b0, 1'b0, 1'b0);
        send_exp(9'h0FF, 1'b0, 1'b1, 1'b0);
        // R5 one-tick glitch at bit centres
        send_exp(9'h0C3, 1'b0, 1'b1, 1'b1);
        send_exp(9'h01E, 1'b0, 1'b1, 1'b1);
        // R3 nine-bit mode
        nine_bit_mode = 1'b1;
        send_exp(9'h1A5, 1'b1, 1'b1, 1'b0);
        send_exp(9'h0FF, 1'b1, 1'b1, 1'b0);
        send_exp(9'h100, 1'b1, 1'b0, 1'b0);
        nine_bit_mode = 1'b0;
        idle(8);
        check(expq.size() == 0, "R2 R3 all frames seen", expq.size(), 0);

        // R4 short low pulse on the idle line
        rx_line = 1'b0;
        idle(20);
        rx_line = 1'b1;
        idle(12 * BITCLK);
        check(data_avail == 1'b0, "R4 short start ignored", data_avail, 0);
        check(expq.size() == 0, "R4 no frame", expq.size(), 0);

        // R9 fill the queue, then overflow
        mon_on = 1'b0;
        idle(4);
        drive_frame(9'h011, 1'b0, 1'b0, 1'b0);
        check(data_avail == 1'b1 && irq == 1'b1, "R8 irq with enable", {data_avail, irq}, 2'b11);
        drive_frame(9'h022, 1'b0, 1'b1, 1'b0);
        check(overrun == 1'b0, "R7 two entries no overrun", overrun, 0);
        drive_frame(9'h033, 1'b0, 1'b1, 1'b0);
        check(overrun == 1'b1, "R9 overrun set", overrun, 1);
        check({rd_ferr, rd_data} == 9'h111, "R6 head status first", {rd_ferr, rd_data}, 9'h111);
        irq_en = 1'b0;
        idle(2);
        check(irq == 1'b0, "R8 irq masked", irq, 0);
        irq_en = 1'b1;
        idle(2);
        check(irq == 1'b1, "R8 irq unmasked", irq, 1);
        pop_once();
        check({rd_ferr, rd_data} == 9'h022, "R6 head status after pop", {rd_ferr, rd_data}, 9'h022);
        // R10 free slot but overrun still blocks
        drive_frame(9'h044, 1'b0, 1'b1, 1'b0);
        check(overrun == 1'b1, "R10 overrun sticky", overrun, 1);
        check(data_avail == 1'b1 && rd_data == 8'h22, "R10 head unchanged", rd_data, 8'h22);
        pop_once();
        check(data_avail == 1'b0, "R10 R9 dropped frames absent", data_avail, 0);
        check(irq == 1'b0, "R8 irq low when empty", irq, 0);
        // R7 pop on empty
        pop_once();
        check(data_avail == 1'b0, "R7 pop on empty", data_avail, 0);

        // R11 disabled receiver
        rx_en = 1'b0;
        idle(4);
        check(overrun == 1'b0, "R11 overrun cleared", overrun, 0);
        drive_frame(9'h055, 1'b0, 1'b1, 1'b0);
        check(data_avail == 1'b0, "R11 no frame while disabled", data_avail, 0);
        rx_en = 1'b1;
        idle(BITCLK);
        drive_frame(9'h066, 1'b0, 1'b1, 1'b0);
        rx_en = 1'b0;
        idle(4);
        rx_en = 1'b1;
        idle(4);
        check(data_avail == 1'b1 && rd_data == 8'h66, "R11 queue kept over toggle", rd_data, 8'h66);
        mon_on = 1'b1;
        expq.push_back(10'h066);
        send_exp(9'h077, 1'b0, 1'b1, 1'b0);
        idle(8);
        check(expq.size() == 0, "R11 reception resumed", expq.size(), 0);
        check(overrun == 1'b0, "R11 overrun stays clear", overrun, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule